// File: doc/BRIEF.md
# Profiling Record Filter

This block sits between the sample collection logic of a statistical profiler and the path that stores records. It takes one finished sample record at a time. Each record holds an operation class, a vector of event flags and a latency. The block then decides whether to keep the record or throw it away. The decision combines three programmable criteria: an operation-class filter, a required-event mask and a minimum latency.

The block produces the latency itself. A counter restarts on the sample-start pulse and counts cycles until the record is accepted, so the figure covers the whole time since sampling began on the operation, not only its execution. A kept record is registered and offered downstream with a valid/ready handshake. While that record waits, the input is held off. A discarded record produces a one-cycle discard pulse and leaves no other trace.

Top module: `prof_rec_filter`

## Requirements
- R1: After reset, `out_valid_o` and `drop_o` are low and `in_ready_o` is high.
- R2: The latency of a record is the number of rising clock edges from the edge that samples `start_i` to the edge that accepts the record. If both happen on the same edge, the latency is 0.
- R3: A record passes the event check only if every bit set in `cfg_evt_mask_i` is also set in `in_evt_i`. A mask of zero passes every record. The bit positions have these meanings:
  - bit 1: the operation retired
  - bit 3: L1 data refill
  - bit 5: TLB refill
  - bit 7: branch mispredict
  - bit 11: misaligned access
- R4: The operation class is encoded on `in_op_i` as 0 load, 1 store, 2 branch and 3 other. When one or more of the class enables (`cfg_ld_en_i`, `cfg_st_en_i`, `cfg_br_en_i`) is set, a record passes if its class matches any enabled class. When no enable is set, every class passes.
- R5: A record passes the latency check only if its latency is greater than or equal to `cfg_min_lat_i`.
- R6: A record that fails any check raises `drop_o` for exactly the one cycle after the accepting edge, and `out_valid_o` stays low.
- R7: A record that passes all checks appears on the output in the cycle after the accepting edge, with `out_valid_o` high and its class, events and latency on `out_op_o`, `out_evt_o` and `out_lat_o`.
- R8: The latency counter saturates at 2^LAT_W-1 instead of wrapping.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the output record stays stable and `in_ready_o` stays low, so no new record is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sampling started on an operation; restarts the latency count |
| in_valid_i | input | 1 | A completed record is offered |
| in_ready_o | output | 1 | The block can accept a record |
| in_op_i | input | 2 | Operation class of the record |
| in_evt_i | input | EVT_W | Event flags of the record |
| cfg_ld_en_i | input | 1 | Keep load records |
| cfg_st_en_i | input | 1 | Keep store records |
| cfg_br_en_i | input | 1 | Keep branch records |
| cfg_evt_mask_i | input | EVT_W | Events a record must have to be kept |
| cfg_min_lat_i | input | LAT_W | Minimum latency for a record to be kept |
| out_valid_o | output | 1 | A kept record is offered |
| out_ready_i | input | 1 | Downstream takes the record |
| out_op_o | output | 2 | Class of the kept record |
| out_evt_o | output | EVT_W | Events of the kept record |
| out_lat_o | output | LAT_W | Measured latency of the kept record |
| drop_o | output | 1 | One-cycle pulse for a discarded record |

## Verification
The assertions run on every cycle and check four properties:
- an offered record stays stable and holds off the input under backpressure;
- a discard pulse never coincides with a valid output;
- every record that reaches the output meets the event mask that was in force when it was accepted;
- every such record also meets the latency threshold in force at that time.

Only the directed scenarios can show the remaining behaviour:
- the exact latency figure and its saturation;
- the any-of behaviour of the class enables and the pass-all case when none is set;
- that records which should pass are not discarded.

// File: rtl/prof_filt_pkg.sv
package prof_filt_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_BRANCH = 2'd2,
    OP_OTHER  = 2'd3
  } op_e;

  localparam int NUM_TYPES = 3;

  localparam int EVT_RETIRED    = 1;
  localparam int EVT_L1D_REFILL = 3;
  localparam int EVT_TLB_REFILL = 5;
  localparam int EVT_MISPRED    = 7;
  localparam int EVT_MISALIGN   = 11;
endpackage

// File: rtl/prof_lat_counter.sv
module prof_lat_counter #(
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [LAT_W-1:0] lat_o
);
  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};

  logic [LAT_W-1:0] cnt_q;

  // cnt_q holds the number of edges seen since the start edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= LAT_W'(1);
    else if (cnt_q != LAT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign lat_o = start_i ? '0 : cnt_q;
endmodule

// File: rtl/prof_rec_decide.sv
module prof_rec_decide
  import prof_filt_pkg::*;
#(
  parameter int EVT_W = 12,
  parameter int LAT_W = 8
) (
  input  logic [NUM_TYPES-1:0] type_en_i,
  input  logic [1:0]           op_i,
  input  logic [EVT_W-1:0]     evt_i,
  input  logic [EVT_W-1:0]     evt_mask_i,
  input  logic [LAT_W-1:0]     lat_i,
  input  logic [LAT_W-1:0]     min_lat_i,
  output logic                 keep_o
);
  logic [NUM_TYPES-1:0] type_hit;
  logic type_ok, evt_ok, lat_ok;

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    assign type_hit[t] = type_en_i[t] && (op_e'(op_i) == op_e'(t));
  end

  assign type_ok = (type_en_i == '0) || (|type_hit);
  assign evt_ok  = (evt_i & evt_mask_i) == evt_mask_i;
  assign lat_ok  = lat_i >= min_lat_i;
  assign keep_o  = type_ok && evt_ok && lat_ok;
endmodule

// File: rtl/prof_out_stage.sv
module prof_out_stage #(
  parameter int EVT_W = 12,
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             keep_i,
  input  logic [1:0]       op_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic [1:0]       out_op_o,
  output logic [EVT_W-1:0] out_evt_o,
  output logic [LAT_W-1:0] out_lat_o,
  output logic             drop_o
);
  logic valid_q, drop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      drop_q <= acc_i && !keep_i;
      if (acc_i && keep_i)           valid_q <= 1'b1;
      else if (valid_q && out_ready_i) valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_op_o  <= '0;
      out_evt_o <= '0;
      out_lat_o <= '0;
    end else if (acc_i && keep_i) begin
      out_op_o  <= op_i;
      out_evt_o <= evt_i;
      out_lat_o <= lat_i;
    end
  end

  assign out_valid_o = valid_q;
  assign drop_o      = drop_q;
endmodule

// File: rtl/prof_rec_filter.sv
module prof_rec_filter
  import prof_filt_pkg::*;
#(
  parameter int EVT_W = 12,
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [1:0]       in_op_i,
  input  logic [EVT_W-1:0] in_evt_i,
  input  logic             cfg_ld_en_i,
  input  logic             cfg_st_en_i,
  input  logic             cfg_br_en_i,
  input  logic [EVT_W-1:0] cfg_evt_mask_i,
  input  logic [LAT_W-1:0] cfg_min_lat_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [1:0]       out_op_o,
  output logic [EVT_W-1:0] out_evt_o,
  output logic [LAT_W-1:0] out_lat_o,
  output logic             drop_o
);
  logic [LAT_W-1:0]     lat;
  logic [NUM_TYPES-1:0] type_en;
  logic                 keep, acc;

  // bit index equals op_e code
  assign type_en    = {cfg_br_en_i, cfg_st_en_i, cfg_ld_en_i};
  assign in_ready_o = !out_valid_o;
  assign acc        = in_valid_i && in_ready_o;

  prof_lat_counter #(.LAT_W(LAT_W)) i_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .lat_o  (lat)
  );

  prof_rec_decide #(.EVT_W(EVT_W), .LAT_W(LAT_W)) i_decide (
    .type_en_i (type_en),
    .op_i      (in_op_i),
    .evt_i     (in_evt_i),
    .evt_mask_i(cfg_evt_mask_i),
    .lat_i     (lat),
    .min_lat_i (cfg_min_lat_i),
    .keep_o    (keep)
  );

  prof_out_stage #(.EVT_W(EVT_W), .LAT_W(LAT_W)) i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .keep_i     (keep),
    .op_i       (in_op_i),
    .evt_i      (in_evt_i),
    .lat_i      (lat),
    .out_ready_i(out_ready_i),
    .out_valid_o(out_valid_o),
    .out_op_o   (out_op_o),
    .out_evt_o  (out_evt_o),
    .out_lat_o  (out_lat_o),
    .drop_o     (drop_o)
  );
endmodule

// File: rtl/prof_rec_filter_chk.sv
module prof_rec_filter_chk #(
  parameter int EVT_W = 12,
  parameter int LAT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [1:0]       out_op_o,
  input logic [EVT_W-1:0] out_evt_o,
  input logic [LAT_W-1:0] out_lat_o,
  input logic             drop_o,
  input logic [EVT_W-1:0] cfg_evt_mask_i,
  input logic [LAT_W-1:0] cfg_min_lat_i
);
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_op_o) && $stable(out_evt_o) && $stable(out_lat_o)); // R9

  AST_INPUT_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o); // R9

  AST_DROP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> !out_valid_o); // R6

  AST_EVT_MASK_MET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> ((out_evt_o & $past(cfg_evt_mask_i)) == $past(cfg_evt_mask_i))); // R3

  AST_MIN_LAT_MET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_lat_o >= $past(cfg_min_lat_i)); // R5
endmodule

bind prof_rec_filter prof_rec_filter_chk #(.EVT_W(EVT_W), .LAT_W(LAT_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_ready_o    (in_ready_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_op_o      (out_op_o),
  .out_evt_o     (out_evt_o),
  .out_lat_o     (out_lat_o),
  .drop_o        (drop_o),
  .cfg_evt_mask_i(cfg_evt_mask_i),
  .cfg_min_lat_i (cfg_min_lat_i)
);

// File: tb/test_prof_rec_filter.sv
`timescale 1ns/1ps
module test_prof_rec_filter;
  import prof_filt_pkg::*;
  localparam int EVT_W = 12;
  localparam int LAT_W = 8;
  localparam int LAT_MAX = (1 << LAT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, in_ready;
  logic [1:0] in_op = '0;
  logic [EVT_W-1:0] in_evt = '0;
  logic ld_en = 1'b0, st_en = 1'b0, br_en = 1'b0;
  logic [EVT_W-1:0] mask = '0;
  logic [LAT_W-1:0] min_lat = '0;
  logic out_valid, out_ready = 1'b0, drop;
  logic [1:0] out_op;
  logic [EVT_W-1:0] out_evt;
  logic [LAT_W-1:0] out_lat;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prof_rec_filter #(.EVT_W(EVT_W), .LAT_W(LAT_W)) i_prof_rec_filter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_op_i(in_op), .in_evt_i(in_evt),
    .cfg_ld_en_i(ld_en), .cfg_st_en_i(st_en), .cfg_br_en_i(br_en),
    .cfg_evt_mask_i(mask), .cfg_min_lat_i(min_lat),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_op_o(out_op), .out_evt_o(out_evt), .out_lat_o(out_lat),
    .drop_o(drop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // start, wait lat edges, offer record; returns at negedge after accept
  task automatic send(input logic [1:0] op, input logic [EVT_W-1:0] evt, input int lat);
    @(negedge clk);
    start = 1'b1;
    in_op = op;
    in_evt = evt;
    if (lat == 0) in_valid = 1'b1;
    else begin
      @(negedge clk);
      start = 1'b0;
      repeat (lat - 1) @(negedge clk);
      in_valid = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_rec(input logic [1:0] op, input logic [EVT_W-1:0] evt, input int lat,
                            input bit keep, input string req);
    int exp_lat;
    exp_lat = (lat > LAT_MAX) ? LAT_MAX : lat;
    send(op, evt, lat);
    if (keep) begin
      chk(out_valid === 1'b1, {req, " R7 kept"}, int'(out_valid), 1);
      chk(drop === 1'b0, {req, " R7 no drop"}, int'(drop), 0);
      chk(out_op === op && out_evt === evt, {req, " R7 fields"}, int'(out_evt), int'(evt));
      chk(int'(out_lat) == exp_lat, {req, " R2 latency"}, int'(out_lat), exp_lat);
      drain();
    end else begin
      chk(drop === 1'b1, {req, " R6 drop"}, int'(drop), 1);
      chk(out_valid === 1'b0, {req, " R6 no out"}, int'(out_valid), 0);
      @(negedge clk);
      chk(drop === 1'b0, {req, " R6 pulse"}, int'(drop), 0);
    end
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0 && drop === 1'b0, "R1 outputs", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 ready", int'(in_ready), 1);
  endtask

  task automatic t_type();
    ld_en = 0; st_en = 0; br_en = 0;
    expect_rec(OP_OTHER, '0, 3, 1, "R4 none set");
    ld_en = 1;
    expect_rec(OP_LOAD, '0, 3, 1, "R4 load only");
    expect_rec(OP_STORE, '0, 3, 0, "R4 store rejected");
    ld_en = 0; st_en = 1;
    expect_rec(OP_STORE, '0, 2, 1, "R4 store only");
    st_en = 0; ld_en = 1; br_en = 1;
    expect_rec(OP_BRANCH, '0, 4, 1, "R4 any-of branch");
    expect_rec(OP_STORE, '0, 4, 0, "R4 any-of store");
    expect_rec(OP_OTHER, '0, 4, 0, "R4 any-of other");
    ld_en = 0; br_en = 0;
  endtask

  task automatic t_event();
    logic [EVT_W-1:0] e;
    mask = '0;
    mask[EVT_RETIRED] = 1'b1;
    mask[EVT_MISPRED] = 1'b1;
    e = mask;
    e[EVT_TLB_REFILL] = 1'b1;
    expect_rec(OP_BRANCH, e, 2, 1, "R3 superset");
    e = '0;
    e[EVT_RETIRED] = 1'b1;
    e[EVT_L1D_REFILL] = 1'b1;
    expect_rec(OP_BRANCH, e, 2, 0, "R3 missing bit");
    mask = '0;
    e = '0;
    e[EVT_MISALIGN] = 1'b1;
    expect_rec(OP_LOAD, e, 2, 1, "R3 zero mask");
  endtask

  task automatic t_latency();
    min_lat = 5;
    expect_rec(OP_LOAD, '0, 5, 1, "R5 equal");
    expect_rec(OP_LOAD, '0, 4, 0, "R5 below");
    expect_rec(OP_LOAD, '0, 9, 1, "R5 above");
    min_lat = 0;
    expect_rec(OP_STORE, '0, 0, 1, "R2 same edge");
    expect_rec(OP_STORE, '0, 1, 1, "R2 one edge");
  endtask

  task automatic t_saturate();
    min_lat = LAT_W'(LAT_MAX);
    expect_rec(OP_LOAD, '0, LAT_MAX + 45, 1, "R8 saturate");
    min_lat = 0;
  endtask

  task automatic t_hold();
    logic [EVT_W-1:0] e;
    e = 12'h0A2;
    send(OP_STORE, e, 6);
    // second record offered while output is pending
    in_op = OP_LOAD;
    in_evt = 12'h800;
    in_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && out_evt === e && out_op === OP_STORE && out_lat == 6,
          "R9 held", int'(out_evt), int'(e));
      chk(in_ready === 1'b0, "R9 input blocked", int'(in_ready), 0);
    end
    in_valid = 1'b0;
    drain();
    chk(out_valid === 1'b0, "R9 no extra record", int'(out_valid), 0);
    chk(drop === 1'b0, "R9 no drop", int'(drop), 0);
    chk(in_ready === 1'b1, "R9 ready again", int'(in_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_type();
    t_event();
    t_latency();
    t_saturate();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule